// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Checker

This block sits beside a DRAM command scheduler and keeps, for every bank, the last command that bank received and a set of down-counters that say how many cycles remain before each kind of follow-on command becomes legal. When the scheduler issues a command, it raises a strobe with the command code and bank. The block then reloads the affected counters from programmable cycle-count timing inputs. Which counters are loaded, and with which sums of timing values, depends on the command that was just issued.

In parallel, the scheduler presents a proposed command and bank. A single flag answers whether that command may go out in the current cycle, taking both the remaining wait and the legality of the command sequence into account. Commands that act on the whole device (precharge-all, refresh, and entry to or exit from power-down or self-refresh) are judged against every bank at once. An issued command whose predecessor on a bank does not permit it raises a one-cycle sequence error. Spacing between activates on different banks and data-bus turnaround are handled elsewhere.

Top module: `bank_timing_checker`

## Requirements
- R1: Synchronous active-low reset clears every counter to zero, marks every bank as precharged, clears the error, so after reset ready_o reads all ones, an activate is allowed and a read is not.
- R2: An activate must wait t_rp after a precharge or precharge-all, t_rtp+t_rp after a read with auto-precharge, and t_wl+t_bl+t_wr+t_rp after a write with auto-precharge on that bank.
- R3: An activate must wait t_xp after a power-down exit, t_xs after a self-refresh exit and t_rfc after a refresh.
- R4: Two activates to one bank are at least t_rc apart, and an activate directly after an activate on the same bank is never allowed.
- R5: A read or write must wait t_rcd after an activate on that bank; a read must in addition wait t_xsdll after a self-refresh exit.
- R6: A precharge must wait t_rtp after a read, t_wl+t_bl+t_wr after a write and t_ras after the last activate on that bank.
- R7: Power-down or self-refresh entry must wait t_rl+t_bl+1 after a read, t_wl+t_bl+t_wr after a write and t_wl+t_bl+t_wr+1 after a write with auto-precharge.
- R8: Power-down exit waits t_cke after power-down entry; self-refresh exit waits t_ckesr after self-refresh entry.
- R9: Precharge-all, refresh, entry and exit commands update every bank and are allowed only when every bank allows them (the wait is the maximum over all banks); prop_bank_i is ignored for them.
- R10: err_o is high for exactly the cycle after an issued command whose predecessor on some affected bank is not a permitted one (for example a read after a precharge, a power-down exit without entry, an activate after an activate).
- R11: A constraint of g cycles from a command issued in cycle T allows the follow-on command from cycle T+g (T+1 when g is 0 or 1); constraints from several commands combine so the latest one governs.
- R12: Command codes on iss_cmd_i and prop_cmd_i are 0 no-op, 1 activate, 2 read, 3 read with auto-precharge, 4 write, 5 write with auto-precharge, 6 precharge, 7 precharge-all, 8 refresh, 9 power-down entry, 10 power-down exit, 11 self-refresh entry, 12 self-refresh exit; a no-op changes no state and is never allowed; ready_o bits are 0 activate, 1 read, 2 write, 3 precharge, 4 refresh, 5 entry, 6 exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_v_i | input | 1 | A command is issued this cycle |
| iss_cmd_i | input | 4 | Code of the issued command |
| iss_bank_i | input | BW | Bank of the issued command |
| prop_cmd_i | input | 4 | Code of the proposed command |
| prop_bank_i | input | BW | Bank of the proposed command |
| t_rp_i | input | TW | Precharge period |
| t_rtp_i | input | TW | Read to precharge |
| t_wr_i | input | TW | Write recovery |
| t_wl_i | input | TW | Write latency |
| t_rl_i | input | TW | Read latency |
| t_bl_i | input | TW | Data burst duration |
| t_rcd_i | input | TW | Activate to read or write |
| t_ras_i | input | TW | Activate to precharge |
| t_rc_i | input | TW | Activate to activate, same bank |
| t_rfc_i | input | TW | Refresh cycle |
| t_xp_i | input | TW | Power-down exit to command |
| t_xs_i | input | TW | Self-refresh exit to command |
| t_xsdll_i | input | TW | Self-refresh exit to read |
| t_cke_i | input | TW | Minimum power-down residency |
| t_ckesr_i | input | TW | Minimum self-refresh residency |
| prop_ok_o | output | 1 | Proposed command may issue this cycle |
| ready_o | output | 7 | Per-class counter-expired flags for prop_bank_i |
| err_o | output | 1 | Illegal command sequence seen last cycle |

## Verification
prop_ok_o and ready_o are combinational on registered state, so they are sampled one nanosecond after the falling edge of the same cycle the proposal is presented; err_o is registered and is read in the cycle after the issue strobe. Timing is checked by issuing a command and counting falling edges until prop_ok_o first rises, which must equal the constraint in cycles worked out from the programmed timing values. A vector table walks one bank through activate, read and precharge cycle by cycle, and directed sequences cover each predecessor case, the all-bank maximum and the error pulse.

// File: rtl/btc_pkg.sv
// Shared command codes, counter classes and sequence-legality rules for the
// per-bank timing checker. Assumes one command per cycle.
package btc_pkg;

    typedef enum logic [3:0] {
        C_NOP  = 4'd0,  C_ACT  = 4'd1,  C_RD   = 4'd2,  C_RDA  = 4'd3,
        C_WR   = 4'd4,  C_WRA  = 4'd5,  C_PRE  = 4'd6,  C_PREA = 4'd7,
        C_REF  = 4'd8,  C_PDE  = 4'd9,  C_PDX  = 4'd10, C_SRE  = 4'd11,
        C_SRX  = 4'd12
    } cmd_e;

    localparam int NCLS = 7;
    localparam int KW   = 3;
    localparam logic [KW-1:0] K_ACT  = 3'd0;
    localparam logic [KW-1:0] K_RD   = 3'd1;
    localparam logic [KW-1:0] K_WR   = 3'd2;
    localparam logic [KW-1:0] K_PRE  = 3'd3;
    localparam logic [KW-1:0] K_REF  = 3'd4;
    localparam logic [KW-1:0] K_PWR  = 3'd5;
    localparam logic [KW-1:0] K_EXIT = 3'd6;

    // Counter class that gates a given command.
    function automatic logic [KW-1:0] cls_of(cmd_e c);
        case (c)
            C_RD, C_RDA:   return K_RD;
            C_WR, C_WRA:   return K_WR;
            C_PRE, C_PREA: return K_PRE;
            C_REF:         return K_REF;
            C_PDE, C_SRE:  return K_PWR;
            C_PDX, C_SRX:  return K_EXIT;
            default:       return K_ACT;
        endcase
    endfunction

    // Commands that act on every bank at once.
    function automatic logic all_bank(cmd_e c);
        return c inside {C_PREA, C_REF, C_PDE, C_PDX, C_SRE, C_SRX};
    endfunction

    // Whether command nx may follow command lst on one bank.
    function automatic logic legal(cmd_e nx, cmd_e lst);
        case (nx)
            C_ACT:                   return lst inside {C_PRE, C_PREA, C_RDA, C_WRA, C_PDX, C_SRX, C_REF};
            C_RD, C_RDA, C_WR, C_WRA: return lst inside {C_ACT, C_RD, C_WR, C_PDX};
            C_PRE:                   return lst inside {C_PRE, C_PREA, C_ACT, C_RD, C_WR, C_PDX};
            C_PREA:                  return !(lst inside {C_PDE, C_SRE});
            C_REF:                   return lst inside {C_PRE, C_PREA, C_RDA, C_WRA, C_REF, C_PDX, C_SRX};
            C_PDE, C_SRE:            return !(lst inside {C_ACT, C_PDE, C_SRE});
            C_PDX:                   return lst == C_PDE;
            C_SRX:                   return lst == C_SRE;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/btc_guard.sv
// Guard calculator: for the command being issued, gives the number of cycles
// each follow-on command class must wait. Zero means no constraint.
// Assumes timing inputs are held stable while commands flow.
module btc_guard
    import btc_pkg::*;
#(
    parameter int TW = 8,
    parameter int CW = TW + 2
) (
    input  cmd_e                      cmd_i,
    input  logic [TW-1:0]             t_rp_i,
    input  logic [TW-1:0]             t_rtp_i,
    input  logic [TW-1:0]             t_wr_i,
    input  logic [TW-1:0]             t_wl_i,
    input  logic [TW-1:0]             t_rl_i,
    input  logic [TW-1:0]             t_bl_i,
    input  logic [TW-1:0]             t_rcd_i,
    input  logic [TW-1:0]             t_ras_i,
    input  logic [TW-1:0]             t_rc_i,
    input  logic [TW-1:0]             t_rfc_i,
    input  logic [TW-1:0]             t_xp_i,
    input  logic [TW-1:0]             t_xs_i,
    input  logic [TW-1:0]             t_xsdll_i,
    input  logic [TW-1:0]             t_cke_i,
    input  logic [TW-1:0]             t_ckesr_i,
    output logic [NCLS-1:0][CW-1:0]   guard_o
);

    logic [CW-1:0] rd_done, wr_done, rda_wait, wra_wait;

    // Shared sums of the data-phase windows.
    always_comb begin
        rd_done  = CW'(t_rl_i) + CW'(t_bl_i) + CW'(1);
        wr_done  = CW'(t_wl_i) + CW'(t_bl_i) + CW'(t_wr_i);
        rda_wait = CW'(t_rtp_i) + CW'(t_rp_i);
        wra_wait = wr_done + CW'(t_rp_i);
    end

    // Per-command guard selection.
    always_comb begin
        guard_o = '0;
        case (cmd_i)
            C_ACT: begin
                guard_o[K_ACT] = CW'(t_rc_i);
                guard_o[K_RD]  = CW'(t_rcd_i);
                guard_o[K_WR]  = CW'(t_rcd_i);
                guard_o[K_PRE] = CW'(t_ras_i);
            end
            C_RD: begin
                guard_o[K_PRE] = CW'(t_rtp_i);
                guard_o[K_PWR] = rd_done;
            end
            C_RDA: begin
                guard_o[K_ACT] = rda_wait;
                guard_o[K_REF] = rda_wait;
                guard_o[K_PWR] = rd_done;
            end
            C_WR: begin
                guard_o[K_PRE] = wr_done;
                guard_o[K_PWR] = wr_done;
            end
            C_WRA: begin
                guard_o[K_ACT] = wra_wait;
                guard_o[K_REF] = wra_wait;
                guard_o[K_PWR] = wr_done + CW'(1);
            end
            C_PRE, C_PREA: begin
                guard_o[K_ACT] = CW'(t_rp_i);
                guard_o[K_REF] = CW'(t_rp_i);
                guard_o[K_PRE] = CW'(t_rp_i);
                guard_o[K_PWR] = CW'(t_rp_i);
            end
            C_REF: begin
                guard_o[K_ACT] = CW'(t_rfc_i);
                guard_o[K_REF] = CW'(t_rfc_i);
                guard_o[K_PRE] = CW'(t_rfc_i);
                guard_o[K_PWR] = CW'(t_rfc_i);
            end
            C_PDE: guard_o[K_EXIT] = CW'(t_cke_i);
            C_SRE: guard_o[K_EXIT] = CW'(t_ckesr_i);
            C_PDX: begin
                guard_o[K_ACT] = CW'(t_xp_i);
                guard_o[K_REF] = CW'(t_xp_i);
                guard_o[K_RD]  = CW'(t_xp_i);
                guard_o[K_WR]  = CW'(t_xp_i);
                guard_o[K_PRE] = CW'(t_xp_i);
                guard_o[K_PWR] = CW'(t_xp_i);
            end
            C_SRX: begin
                guard_o[K_ACT] = CW'(t_xs_i);
                guard_o[K_REF] = CW'(t_xs_i);
                guard_o[K_RD]  = CW'(t_xsdll_i);
                guard_o[K_WR]  = CW'(t_xs_i);
                guard_o[K_PRE] = CW'(t_xs_i);
                guard_o[K_PWR] = CW'(t_xs_i);
            end
            default: guard_o = '0;
        endcase
    end

endmodule

// File: rtl/btc_bank.sv
// One bank's timing state: last command and one saturating down-counter per
// command class. On an update each counter takes the larger of its own
// decremented value and the new guard minus one, so older, longer
// constraints survive. Assumes at most one update per cycle.
module btc_bank
    import btc_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  cmd_e                    cmd_i,
    input  logic [NCLS-1:0][CW-1:0] guard_i,
    output cmd_e                    last_o,
    output logic [NCLS-1:0]         rdy_o
);

    logic [NCLS-1:0][CW-1:0] cnt_q, cnt_d;
    cmd_e                    last_q;

    // Next counter values: saturating step down, merged with a fresh guard.
    always_comb begin
        for (int k = 0; k < NCLS; k++) begin
            logic [CW-1:0] dec, ld;
            dec = (cnt_q[k] != '0) ? cnt_q[k] - CW'(1) : '0;
            ld  = (guard_i[k] != '0) ? guard_i[k] - CW'(1) : '0;
            cnt_d[k] = (upd_i && (ld > dec)) ? ld : dec;
        end
    end

    // Counter and last-command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= C_PRE;
        end else begin
            cnt_q <= cnt_d;
            if (upd_i) last_q <= cmd_i;
        end
    end

    // Ready flags per class.
    always_comb begin
        for (int k = 0; k < NCLS; k++) rdy_o[k] = (cnt_q[k] == '0);
    end

    assign last_o = last_q;

    AST_RST_STATE: assert property (@(posedge clk) !rst_n |=> (cnt_q == '0 && last_q == C_PRE)); // R1

    for (genvar k = 0; k < NCLS; k++) begin : g_chk
        AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_i && guard_i[k] > CW'(1)) |=> (cnt_q[k] != '0)); // R11
        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd_i && cnt_q[k] != '0) |=> (cnt_q[k] == $past(cnt_q[k]) - CW'(1))); // R11
    end

endmodule

// File: rtl/bank_timing_checker.sv
// Per-bank DRAM command timing checker top. Routes an issued command to its
// bank (or all banks for device-wide commands), flags illegal sequences one
// cycle later, and answers whether a proposed command may issue now.
// Assumes at most one issued command per cycle.
module bank_timing_checker
    import btc_pkg::*;
#(
    parameter int NB = 8,
    parameter int TW = 8,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1,
    localparam int CW = TW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_v_i,
    input  logic [3:0]      iss_cmd_i,
    input  logic [BW-1:0]   iss_bank_i,
    input  logic [3:0]      prop_cmd_i,
    input  logic [BW-1:0]   prop_bank_i,
    input  logic [TW-1:0]   t_rp_i,
    input  logic [TW-1:0]   t_rtp_i,
    input  logic [TW-1:0]   t_wr_i,
    input  logic [TW-1:0]   t_wl_i,
    input  logic [TW-1:0]   t_rl_i,
    input  logic [TW-1:0]   t_bl_i,
    input  logic [TW-1:0]   t_rcd_i,
    input  logic [TW-1:0]   t_ras_i,
    input  logic [TW-1:0]   t_rc_i,
    input  logic [TW-1:0]   t_rfc_i,
    input  logic [TW-1:0]   t_xp_i,
    input  logic [TW-1:0]   t_xs_i,
    input  logic [TW-1:0]   t_xsdll_i,
    input  logic [TW-1:0]   t_cke_i,
    input  logic [TW-1:0]   t_ckesr_i,
    output logic            prop_ok_o,
    output logic [6:0]      ready_o,
    output logic            err_o
);

    cmd_e                    ic, pc;
    logic [NCLS-1:0][CW-1:0] guard_w;
    cmd_e                    last_w [NB];
    logic [NCLS-1:0]         rdy_w  [NB];
    logic [NB-1:0]           upd_w, bad_w, okb_w;
    logic                    err_q;

    assign ic = cmd_e'(iss_cmd_i);
    assign pc = cmd_e'(prop_cmd_i);

    btc_guard #(.TW(TW), .CW(CW)) u_guard (
        .cmd_i(ic),
        .t_rp_i(t_rp_i), .t_rtp_i(t_rtp_i), .t_wr_i(t_wr_i), .t_wl_i(t_wl_i),
        .t_rl_i(t_rl_i), .t_bl_i(t_bl_i), .t_rcd_i(t_rcd_i), .t_ras_i(t_ras_i),
        .t_rc_i(t_rc_i), .t_rfc_i(t_rfc_i), .t_xp_i(t_xp_i), .t_xs_i(t_xs_i),
        .t_xsdll_i(t_xsdll_i), .t_cke_i(t_cke_i), .t_ckesr_i(t_ckesr_i),
        .guard_o(guard_w)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        // Bank select for the issued command.
        assign upd_w[b] = iss_v_i && (ic != C_NOP) && (all_bank(ic) || iss_bank_i == BW'(b));

        btc_bank #(.CW(CW)) u_bank (
            .clk(clk), .rst_n(rst_n), .upd_i(upd_w[b]), .cmd_i(ic),
            .guard_i(guard_w), .last_o(last_w[b]), .rdy_o(rdy_w[b])
        );

        // Sequence check for the issue and readiness for the proposal.
        assign bad_w[b] = upd_w[b] && !legal(ic, last_w[b]);
        assign okb_w[b] = rdy_w[b][cls_of(pc)] && legal(pc, last_w[b]);
    end

    // Proposal answer: all banks for device-wide commands, else one bank.
    always_comb begin
        if (pc == C_NOP)       prop_ok_o = 1'b0;
        else if (all_bank(pc)) prop_ok_o = &okb_w;
        else                   prop_ok_o = okb_w[prop_bank_i];
    end

    assign ready_o = rdy_w[prop_bank_i];

    // Registered sequence error.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= |bad_w;
    end

    assign err_o = err_q;

    AST_ERR_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(iss_v_i)); // R10
    AST_SAME_ACT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_v_i && ic == C_ACT) |=> !(prop_ok_o && pc == C_ACT && prop_bank_i == $past(iss_bank_i))); // R4

endmodule

// File: tb/test_bank_timing_checker.sv
module test_bank_timing_checker;
    import btc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_v = 1'b0;
    logic [3:0] iss_cmd = 4'd0;
    logic [2:0] iss_bank = 3'd0;
    logic [3:0] prop_cmd = 4'd0;
    logic [2:0] prop_bank = 3'd0;
    logic       prop_ok, err;
    logic [6:0] ready;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    bank_timing_checker i_bank_timing_checker (
        .clk(clk), .rst_n(rst_n), .iss_v_i(iss_v), .iss_cmd_i(iss_cmd),
        .iss_bank_i(iss_bank), .prop_cmd_i(prop_cmd), .prop_bank_i(prop_bank),
        .t_rp_i(8'd3), .t_rtp_i(8'd2), .t_wr_i(8'd4), .t_wl_i(8'd2),
        .t_rl_i(8'd3), .t_bl_i(8'd2), .t_rcd_i(8'd3), .t_ras_i(8'd6),
        .t_rc_i(8'd11), .t_rfc_i(8'd8), .t_xp_i(8'd3), .t_xs_i(8'd10),
        .t_xsdll_i(8'd15), .t_cke_i(8'd3), .t_ckesr_i(8'd5),
        .prop_ok_o(prop_ok), .ready_o(ready), .err_o(err)
    );

    // {iss_v, iss_cmd, iss_bank, prop_cmd, prop_bank, exp_ok, exp_err}
    localparam logic [16:0] VEC [15] = '{
        {1'b0, 4'd0, 3'd0, 4'd1, 3'd0, 1'b1, 1'b0},
        {1'b1, 4'd1, 3'd0, 4'd2, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd2, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd2, 3'd0, 1'b0, 1'b0},
        {1'b1, 4'd2, 3'd0, 4'd2, 3'd0, 1'b1, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd6, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd6, 3'd0, 1'b0, 1'b0},
        {1'b1, 4'd6, 3'd0, 4'd6, 3'd0, 1'b1, 1'b0},
        {1'b1, 4'd2, 3'd1, 4'd1, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd2, 3'd0, 1'b0, 1'b1},
        {1'b0, 4'd0, 3'd0, 4'd1, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd1, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd1, 3'd0, 1'b1, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd8, 3'd0, 1'b0, 1'b0},
        {1'b0, 4'd0, 3'd0, 4'd7, 3'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        iss_v = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_issue(input cmd_e c, input int b);
        iss_v = 1'b1; iss_cmd = c; iss_bank = 3'(b);
        @(negedge clk);
        iss_v = 1'b0;
        #1;
    endtask

    // Issue in the current cycle; count cycles until the proposal is allowed.
    task automatic meas(input cmd_e ic, input int ib, input cmd_e pcm, input int pb, output int k);
        iss_v = 1'b1; iss_cmd = ic; iss_bank = 3'(ib);
        prop_cmd = pcm; prop_bank = 3'(pb);
        k = 0;
        forever begin
            @(negedge clk);
            iss_v = 1'b0;
            #1;
            k++;
            if (prop_ok) break;
            if (k > 60) begin k = 99; break; end
        end
    endtask

    task automatic open_bank(input int b);
        do_reset();
        do_issue(C_ACT, b);
        idle(12);
    endtask

    initial begin
        int k;
        do_reset();

        // R1: reset state at the ports
        prop_cmd = C_ACT; prop_bank = 3'd0; #1;
        chk("R1 ready after reset", int'(ready), 32'h7F);
        chk("R1 activate allowed after reset", int'(prop_ok), 1);
        chk("R1 error low after reset", int'(err), 0);
        prop_cmd = C_RD; #1;
        chk("R1 read refused on precharged bank", int'(prop_ok), 0);

        // R12: a strobed no-op changes nothing and is never allowed
        do_issue(C_NOP, 0);
        prop_cmd = C_NOP; #1;
        chk("R12 no-op never allowed", int'(prop_ok), 0);
        chk("R12 no-op leaves counters", int'(ready), 32'h7F);
        chk("R12 no-op raises no error", int'(err), 0);

        // R11 / R4 / R6 / R10 / R9: cycle-by-cycle vector walk
        do_reset();
        for (int i = 0; i < 15; i++) begin
            logic [16:0] row;
            row = VEC[i];
            iss_v = row[16]; iss_cmd = row[15:12]; iss_bank = row[11:9];
            prop_cmd = row[8:5]; prop_bank = row[4:2];
            #1;
            chk($sformatf("R11 R4 row %0d allow", i), int'(prop_ok), int'(row[1]));
            chk($sformatf("R10 row %0d error", i), int'(err), int'(row[0]));
            @(negedge clk);
            iss_v = 1'b0;
            #1;
        end

        // R5: read after activate waits t_rcd
        do_reset();
        meas(C_ACT, 2, C_RD, 2, k);
        chk("R5 activate to read", k, 3);

        // R2: activate after precharge, read and write with auto-precharge
        open_bank(6);
        meas(C_PRE, 6, C_ACT, 6, k);
        chk("R2 precharge to activate", k, 3);
        open_bank(0);
        meas(C_RDA, 0, C_ACT, 0, k);
        chk("R2 read auto-precharge to activate", k, 5);
        open_bank(0);
        meas(C_WRA, 0, C_ACT, 0, k);
        chk("R2 write auto-precharge to activate", k, 11);

        // R6: precharge after read, write and activate
        open_bank(0);
        meas(C_RD, 0, C_PRE, 0, k);
        chk("R6 read to precharge", k, 2);
        open_bank(0);
        meas(C_WR, 0, C_PRE, 0, k);
        chk("R6 write to precharge", k, 8);
        do_reset();
        meas(C_ACT, 0, C_PRE, 0, k);
        chk("R6 activate to precharge", k, 6);

        // R7: power-down entry after read, write, write with auto-precharge
        open_bank(0);
        meas(C_RD, 0, C_PDE, 0, k);
        chk("R7 read to entry", k, 6);
        open_bank(0);
        meas(C_WR, 0, C_PDE, 0, k);
        chk("R7 write to entry", k, 8);
        open_bank(0);
        meas(C_WRA, 0, C_PDE, 0, k);
        chk("R7 write auto-precharge to entry", k, 9);

        // R8 and R3: power-down residency then exit to activate
        do_reset();
        meas(C_PDE, 0, C_PDX, 0, k);
        chk("R8 power-down entry to exit", k, 3);
        meas(C_PDX, 0, C_ACT, 3, k);
        chk("R3 power-down exit to activate", k, 3);

        // R8, R3, R5: self-refresh residency, exit, then read needs t_xsdll
        do_reset();
        meas(C_SRE, 0, C_SRX, 0, k);
        chk("R8 self-refresh entry to exit", k, 5);
        meas(C_SRX, 0, C_ACT, 0, k);
        chk("R3 self-refresh exit to activate", k, 10);
        meas(C_ACT, 0, C_RD, 0, k);
        chk("R5 read held by self-refresh exit window", k, 5);

        // R3: refresh to activate
        do_reset();
        meas(C_REF, 0, C_ACT, 5, k);
        chk("R3 refresh to activate", k, 8);

        // R9: precharge-all waits for the slowest bank, prop bank ignored
        do_reset();
        do_issue(C_ACT, 1);
        meas(C_ACT, 4, C_PREA, 0, k);
        chk("R9 precharge-all takes the bank maximum", k, 6);

        // R10: exit without entry raises a single-cycle error
        do_reset();
        do_issue(C_PDX, 0);
        chk("R10 exit without entry flagged", int'(err), 1);
        idle(1);
        chk("R10 error lasts one cycle", int'(err), 0);

        // R4 / R10: activate after activate is never allowed and is flagged
        do_reset();
        do_issue(C_ACT, 2);
        idle(15);
        prop_cmd = C_ACT; prop_bank = 3'd2; #1;
        chk("R4 activate on open bank refused", int'(prop_ok), 0);
        do_issue(C_ACT, 2);
        chk("R10 activate after activate flagged", int'(err), 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule